// File: doc/BRIEF.md
# Vectored Interrupt Controller with Critical Steering

This block gathers 32 interrupt request lines and reduces them to two processor interrupt outputs: a normal one and a critical one. A processor configures and services it through a simple register port with an address, write data, a write strobe, a read strobe and read data. Each request line is latched into a status bit. A trigger register sets each line as edge-sensitive, which is sticky until cleared, or level-sensitive, which follows the line. An enable mask gates every status bit. A critical-select mask steers each enabled bit to the critical output or to the normal output.

For the critical path the block also produces a vector address. It scans the pending critical bits from a programmable end of the register, either from bit 0 upward or from bit 31 downward. The result is a software-supplied base plus 512 bytes for each position between the scan start and the first pending bit, so software can jump straight to a handler slot. A build parameter can remove the vector logic. When it is removed, the vector and vector-configuration offsets read as zero.

All state is held in flops on one clock. The outputs and the vector are combinational functions of that state. A register write therefore shows on the outputs in the cycle after the write edge.

Top module: `crit_vec_intc`

## Requirements
- R1: The register window sits at `BASE_ADDR` (default 0x30) and spans offsets 0 to 8. The offsets are: 0 status (write clears), 1 status set, 2 enable, 3 critical select, 4 polarity, 5 trigger, 6 masked status, 7 vector, 8 vector configuration. Addresses outside the window read zero. Read data is zero whenever the read strobe is low.
- R2: Request input n maps to register bit 31-n, so input 0 is bit 31 and input 31 is bit 0.
- R3: With trigger bit = 1 the line is edge-sensitive. The status bit sets in the cycle after the input is sampled high when it was low the cycle before. It stays set when the input drops. An input that is held high does not set the bit again after software clears it.
- R4: With trigger bit = 0 the line is level-sensitive. Whenever the input differs from its previous sample, both the status bit and an internal level-held bit take the new input value.
- R5: A write to offset 0 clears every status bit written as 1 and then ORs in all level-held bits. A write to offset 1 ORs the written value into status. Both offsets read back the status.
- R6: The normal output is high when status & enable & ~critical is non-zero. The critical output is high when status & enable & critical is non-zero. Both change in the cycle after the register write or input event that causes the change.
- R7: Offset 6 reads status & enable. Writes to offsets 6 and 7 change no state.
- R8: The polarity register (offset 4) reads back what was written and has no effect on either output.
- R9: A write to offset 8 stores the written value with bit 1 forced to 0. Bit 0 is the scan direction and bits 31:2 are the vector base.
- R10: With P = status & enable & critical non-zero, offset 7 reads base + 512*k. With direction 0, k is the index of the lowest set bit of P. With direction 1, k is 31 minus the index of the highest set bit. With P zero, offset 7 reads 0.
- R11: After reset every register is zero, both outputs are low, and every offset reads zero.
- R12: With `VEC_EN` = 0, offsets 7 and 8 always read zero, and the outputs behave as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines; line n maps to register bit 31-n |
| cfg_addr | input | ADDR_W | Register port address |
| cfg_wdata | input | 32 | Register write data |
| cfg_we | input | 1 | Write strobe, one write per cycle it is high |
| cfg_re | input | 1 | Read strobe; read data is valid in the same cycle |
| cfg_rdata | output | 32 | Read data, zero when the strobe is low or the address is outside the window |
| int_norm | output | 1 | Normal interrupt output |
| int_crit | output | 1 | Critical interrupt output |

## Verification
The assertions assume the request lines are already synchronous to `clk`, so a one-cycle pulse counts as a real event. They also assume the port carries at most one write per cycle, because address and strobe are shared. The property on the set alias holds only when every line is edge-sensitive. When a line is level-sensitive, an input change in the same cycle as the write may legitimately override the written 1. The bench therefore changes the request lines and drives the port only just after a rising edge, one access per cycle. In its random phase it mixes input toggles, in-window writes and out-of-window writes. A behavioural model follows the same ordering: the register write is applied first, then the input events.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned REG_CNT = 9;

  typedef enum logic [3:0] {
    OFS_STAT  = 4'd0,
    OFS_SETS  = 4'd1,
    OFS_ENAB  = 4'd2,
    OFS_CRIT  = 4'd3,
    OFS_POL   = 4'd4,
    OFS_TRIG  = 4'd5,
    OFS_MSTAT = 4'd6,
    OFS_VEC   = 4'd7,
    OFS_VCFG  = 4'd8
  } reg_ofs_e;

endpackage

// File: rtl/intc_latch.sv
module intc_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_bits,
  input  logic [W-1:0] trig,
  input  logic         clr_we,
  input  logic         set_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status
);

  logic [W-1:0] prev_q, stat_q, lvl_q;
  logic [W-1:0] stat_n, lvl_n;
  logic [W-1:0] rise, chg;

  assign rise = req_bits & ~prev_q;
  assign chg  = req_bits ^ prev_q;

  always_comb begin
    stat_n = stat_q;
    lvl_n  = lvl_q;
    if (clr_we) stat_n = (stat_n & ~wdata) | lvl_q;
    if (set_we) stat_n = stat_n | wdata;
    for (int b = 0; b < int'(W); b++) begin
      if (trig[b]) begin
        if (rise[b]) stat_n[b] = 1'b1;
      end else if (chg[b]) begin
        stat_n[b] = req_bits[b];
        lvl_n[b]  = req_bits[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      lvl_q  <= '0;
    end else begin
      prev_q <= req_bits;
      stat_q <= stat_n;
      lvl_q  <= lvl_n;
    end
  end

  assign status = stat_q;

  p_set_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && (&trig)) |=> ((stat_q & $past(wdata)) == $past(wdata)));

  for (genvar b = 0; b < int'(W); b++) begin : g_bit_chk
    p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[b] && stat_q[b] && !(clr_we && wdata[b])) |=> stat_q[b]);
    p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[b] && req_bits[b] && !prev_q[b]) |=> stat_q[b]);
    p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig[b] && (req_bits[b] != prev_q[b])) |=>
        ((stat_q[b] == $past(req_bits[b])) && (lvl_q[b] == $past(req_bits[b]))));
  end

endmodule

// File: rtl/intc_vscan.sv
module intc_vscan #(
  parameter int unsigned W         = 32,
  parameter int unsigned STEP_LOG2 = 9,
  parameter bit          ENABLE    = 1'b1
) (
  input  logic [W-1:0] pend,
  input  logic [W-1:0] vcfg,
  output logic [W-1:0] vec
);

  localparam int unsigned IDX_W = $clog2(W);

  if (ENABLE) begin : g_scan
    logic [W-1:0]     rev, scan, base;
    logic [IDX_W-1:0] k;
    logic             found;

    for (genvar i = 0; i < int'(W); i++) begin : g_rev
      assign rev[i] = pend[W-1-i];
    end

    assign scan = vcfg[0] ? rev : pend;
    assign base = vcfg & ~W'(3);

    always_comb begin
      k     = '0;
      found = 1'b0;
      for (int i = 0; i < int'(W); i++) begin
        if (!found && scan[i]) begin
          k     = IDX_W'(i);
          found = 1'b1;
        end
      end
    end

    assign vec = found ? (base + (W'(k) << STEP_LOG2)) : '0;
  end else begin : g_none
    assign vec = '0;
  end

endmodule

// File: rtl/crit_vec_intc.sv
module crit_vec_intc #(
  parameter int unsigned ADDR_W        = 10,
  parameter int unsigned BASE_ADDR     = 'h30,
  parameter int unsigned DATA_W        = 32,
  parameter bit          VEC_EN        = 1'b1,
  parameter int unsigned VEC_STEP_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] irq_in,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  input  logic              cfg_re,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              int_norm,
  output logic              int_crit
);
  import intc_pkg::*;

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(REG_CNT);

  logic [ADDR_W-1:0]  ofs;
  logic               in_win;
  logic [REG_CNT-1:0] wr_hit;
  logic [DATA_W-1:0]  req_bits;
  logic [DATA_W-1:0]  status, crit_pend, vec_val, vcfg;
  logic [DATA_W-1:0]  en_q, crit_q, pol_q, trig_q;
  logic [DATA_W-1:0]  en_n, crit_n, pol_n, trig_n;
  logic [DATA_W-1:0]  rd_mux;

  // address decode
  assign ofs    = cfg_addr - BASE_A;
  assign in_win = (cfg_addr >= BASE_A) && (ofs < CNT_A);

  for (genvar i = 0; i < int'(REG_CNT); i++) begin : g_hit
    assign wr_hit[i] = cfg_we && in_win && (ofs == ADDR_W'(i));
  end

  // line n -> register bit (DATA_W-1-n)
  for (genvar n = 0; n < int'(DATA_W); n++) begin : g_map
    assign req_bits[DATA_W-1-n] = irq_in[n];
  end

  intc_latch #(.W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_bits (req_bits),
    .trig     (trig_q),
    .clr_we   (wr_hit[OFS_STAT]),
    .set_we   (wr_hit[OFS_SETS]),
    .wdata    (cfg_wdata),
    .status   (status)
  );

  // configuration registers: next state
  always_comb begin
    en_n   = en_q;
    crit_n = crit_q;
    pol_n  = pol_q;
    trig_n = trig_q;
    if (wr_hit[OFS_ENAB]) en_n   = cfg_wdata;
    if (wr_hit[OFS_CRIT]) crit_n = cfg_wdata;
    if (wr_hit[OFS_POL])  pol_n  = cfg_wdata;
    if (wr_hit[OFS_TRIG]) trig_n = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else begin
      en_q   <= en_n;
      crit_q <= crit_n;
      pol_q  <= pol_n;
      trig_q <= trig_n;
    end
  end

  if (VEC_EN) begin : g_vcfg
    logic [DATA_W-1:0] vcfg_q, vcfg_n;
    always_comb begin
      vcfg_n = vcfg_q;
      if (wr_hit[OFS_VCFG]) vcfg_n = cfg_wdata & ~DATA_W'(2);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vcfg_q <= '0;
      else        vcfg_q <= vcfg_n;
    end
    assign vcfg = vcfg_q;

    p_vcfg_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[OFS_VCFG] |=> (vcfg_q == ($past(cfg_wdata) & ~DATA_W'(2))));
    p_vec_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (crit_pend != '0) |->
        (vec_val[VEC_STEP_LOG2-1:2] == vcfg_q[VEC_STEP_LOG2-1:2]));
  end else begin : g_novcfg
    assign vcfg = '0;
  end

  // output combine
  assign crit_pend = status & en_q & crit_q;
  assign int_crit  = |crit_pend;
  assign int_norm  = |(status & en_q & ~crit_q);

  intc_vscan #(
    .W         (DATA_W),
    .STEP_LOG2 (VEC_STEP_LOG2),
    .ENABLE    (VEC_EN)
  ) u_vscan (
    .pend (crit_pend),
    .vcfg (vcfg),
    .vec  (vec_val)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    case (reg_ofs_e'(ofs[3:0]))
      OFS_STAT, OFS_SETS: rd_mux = status;
      OFS_ENAB:           rd_mux = en_q;
      OFS_CRIT:           rd_mux = crit_q;
      OFS_POL:            rd_mux = pol_q;
      OFS_TRIG:           rd_mux = trig_q;
      OFS_MSTAT:          rd_mux = status & en_q;
      OFS_VEC:            rd_mux = vec_val;
      OFS_VCFG:           rd_mux = vcfg;
      default:            rd_mux = '0;
    endcase
  end

  assign cfg_rdata = (cfg_re && in_win) ? rd_mux : '0;

  p_en_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[OFS_ENAB] && (cfg_wdata == '0)) |=> (!int_norm && !int_crit));
  p_ro_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[OFS_MSTAT] || wr_hit[OFS_VEC]) |=>
      ($stable(en_q) && $stable(crit_q) && $stable(pol_q) &&
       $stable(trig_q) && $stable(vcfg)));
  p_vec_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_pend == '0) |-> (vec_val == '0));

endmodule

// File: tb/crit_vec_intc_test.sv
module crit_vec_intc_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] irq, wdata;
  logic [9:0]  addr;
  logic        we, re;
  logic [31:0] rdata, rdata2;
  logic        nrm, crt, nrm2, crt2;

  crit_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_we(we), .cfg_re(re), .cfg_rdata(rdata), .int_norm(nrm), .int_crit(crt));

  crit_vec_intc #(.VEC_EN(1'b0)) uut_nv (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_addr(addr), .cfg_wdata(wdata),
    .cfg_we(we), .cfg_re(re), .cfg_rdata(rdata2), .int_norm(nrm2), .int_crit(crt2));

  int    n_chk = 0, n_fail = 0, cycles = 0;
  bit    done = 1'b0;
  string tag = "R11";

  // behavioural reference state
  logic [31:0] m_stat, m_lvl, m_en, m_crit, m_pol, m_trig, m_vcfg, m_prev;

  function automatic logic [31:0] m_vector();
    logic [31:0] p = m_stat & m_en & m_crit;
    if (p == 0) return 32'h0;
    if (m_vcfg[0]) begin
      for (int i = 31; i >= 0; i--)
        if (p[i]) return (m_vcfg & 32'hFFFF_FFFC) + 32'((31 - i) * 512);
    end else begin
      for (int i = 0; i < 32; i++)
        if (p[i]) return (m_vcfg & 32'hFFFF_FFFC) + 32'(i * 512);
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_read(logic [9:0] a, bit vec_on);
    int off = int'(a) - 'h30;
    if (off < 0 || off > 8) return 32'h0;
    case (off)
      0, 1: return m_stat;
      2: return m_en;
      3: return m_crit;
      4: return m_pol;
      5: return m_trig;
      6: return m_stat & m_en;
      7: return vec_on ? m_vector() : 32'h0;
      default: return vec_on ? m_vcfg : 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] s, l, t_old;
    int off;
    if (!rst_n) begin
      m_stat = 0; m_lvl = 0; m_en = 0; m_crit = 0;
      m_pol = 0; m_trig = 0; m_vcfg = 0; m_prev = 0;
    end else begin
      s = m_stat; l = m_lvl; t_old = m_trig;
      off = int'(addr) - 'h30;
      if (we && off >= 0 && off <= 8) begin
        case (off)
          0: s = (s & ~wdata) | m_lvl;
          1: s = s | wdata;
          2: m_en = wdata;
          3: m_crit = wdata;
          4: m_pol = wdata;
          5: m_trig = wdata;
          8: m_vcfg = wdata & 32'hFFFF_FFFD;
          default: ;
        endcase
      end
      for (int n = 0; n < 32; n++) begin
        if (t_old[31-n]) begin
          if (irq[n] && !m_prev[n]) s[31-n] = 1'b1;
        end else if (irq[n] != m_prev[n]) begin
          s[31-n] = irq[n];
          l[31-n] = irq[n];
        end
      end
      m_prev = irq; m_stat = s; m_lvl = l;
    end
  end

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", t, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({tag, " norm"}, {31'b0, nrm},  {31'b0, |(m_stat & m_en & ~m_crit)});
      check({tag, " crit"}, {31'b0, crt},  {31'b0, |(m_stat & m_en & m_crit)});
      check({tag, " norm/nv"}, {31'b0, nrm2}, {31'b0, |(m_stat & m_en & ~m_crit)});
      check({tag, " crit/nv"}, {31'b0, crt2}, {31'b0, |(m_stat & m_en & m_crit)});
      if (re) begin
        check({tag, " rdata"}, rdata, m_read(addr, 1'b1));
        check({tag, " rdata/nv"}, rdata2, m_read(addr, 1'b0));
      end else begin
        check("R1 rdata idle", rdata, 32'h0);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(int off, logic [31:0] d);
    we = 1'b1; addr = 10'(32'h30 + off); wdata = d; re = 1'b0;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd_at(logic [9:0] a, logic [31:0] exp, string t);
    re = 1'b1; addr = a;
    @(negedge clk);
    check(t, rdata, exp);
    cyc();
    re = 1'b0;
  endtask

  task automatic rd(int off, logic [31:0] exp, string t);
    rd_at(10'(32'h30 + off), exp, t);
  endtask

  task automatic outs(logic en, logic ec, string t);
    @(negedge clk);
    check({t, " norm"}, {31'b0, nrm}, {31'b0, en});
    check({t, " crit"}, {31'b0, crt}, {31'b0, ec});
    cyc();
  endtask

  initial begin
    rst_n = 1'b0; irq = 0; wdata = 0; addr = 0; we = 0; re = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R11: reset state
    tag = "R11";
    outs(1'b0, 1'b0, "R11");
    for (int o = 0; o < 9; o++) rd(o, 32'h0, "R11 reg");

    // R2: line to bit mapping
    tag = "R2";
    irq[0] = 1'b1; cyc();
    rd(0, 32'h8000_0000, "R2 line0");
    irq[0] = 1'b0; irq[31] = 1'b1; cyc();
    rd(0, 32'h0000_0001, "R2 line31");
    irq = 0; cyc();

    // R4: level following, R5 clear overridden by level-held bit
    tag = "R4";
    irq[3] = 1'b1; cyc();
    rd(0, 32'h1000_0000, "R4 level high");
    tag = "R5";
    wr(0, 32'h1000_0000);
    rd(0, 32'h1000_0000, "R5 clear held by level");
    tag = "R4";
    irq[3] = 1'b0; cyc();
    rd(0, 32'h0, "R4 level low");

    // R5: set alias and clear
    tag = "R5";
    wr(1, 32'h0000_0004);
    rd(1, 32'h0000_0004, "R5 set alias");
    wr(0, 32'h0000_0004);
    rd(0, 32'h0, "R5 clear");

    // R3: edge-sensitive line 5 (bit 26)
    tag = "R3";
    wr(5, 32'h0400_0000);
    irq[5] = 1'b1; cyc();
    irq[5] = 1'b0; cyc();
    rd(0, 32'h0400_0000, "R3 sticky after drop");
    wr(0, 32'h0400_0000);
    rd(0, 32'h0, "R3 cleared");
    irq[5] = 1'b1; cyc();
    wr(0, 32'h0400_0000);
    cyc(); cyc();
    rd(0, 32'h0, "R3 held high no re-set");
    irq[5] = 1'b0; cyc();

    // R6: output steering
    tag = "R6";
    wr(1, 32'hFFFF_FFFF);
    outs(1'b0, 1'b0, "R6 disabled");
    wr(2, 32'h0000_00F0);
    outs(1'b1, 1'b0, "R6 normal");
    wr(3, 32'h0000_0010);
    outs(1'b1, 1'b1, "R6 both");
    wr(3, 32'h0000_00F0);
    outs(1'b0, 1'b1, "R6 critical");

    // R7: masked status and ignored writes
    tag = "R7";
    rd(6, 32'h0000_00F0, "R7 masked");
    wr(6, 32'h0000_FFFF);
    wr(7, 32'h0000_FFFF);
    rd(2, 32'h0000_00F0, "R7 enable kept");
    rd(3, 32'h0000_00F0, "R7 critical kept");
    rd(6, 32'h0000_00F0, "R7 masked kept");

    // R8: polarity is storage only
    tag = "R8";
    wr(4, 32'hFFFF_FFFF);
    rd(4, 32'hFFFF_FFFF, "R8 readback");
    outs(1'b0, 1'b1, "R8 no effect");

    // R9: vector configuration store
    tag = "R9";
    wr(8, 32'h0001_0003);
    rd(8, 32'h0001_0001, "R9 bit1 cleared");

    // R10: vector computation (pending bits 4..7)
    tag = "R10";
    rd(7, 32'h0001_3000, "R10 downward scan");
    wr(8, 32'h0002_0000);
    rd(7, 32'h0002_0800, "R10 upward scan");
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'h8000_0000);
    wr(8, 32'h0000_01FC);
    rd(7, 32'h0000_3FFC, "R10 bit31 upward");
    wr(8, 32'h0000_01FD);
    rd(7, 32'h0000_01FC, "R10 bit31 downward");
    wr(3, 32'h0);
    rd(7, 32'h0, "R10 none pending");

    // R12: vector logic removed
    tag = "R12";
    re = 1'b1; addr = 10'h38;
    @(negedge clk); check("R12 vcfg", rdata2, 32'h0);
    cyc();
    wr(3, 32'h0000_0100);
    re = 1'b1; addr = 10'h37;
    @(negedge clk); check("R12 vector", rdata2, 32'h0);
    cyc(); re = 1'b0;

    // R1: window edges
    tag = "R1";
    rd_at(10'h39, 32'h0, "R1 above window");
    rd_at(10'h2F, 32'h0, "R1 below window");
    rd(3, 32'h0000_0100, "R1 offset 3");

    // random mixed traffic, compared against the model every clock
    tag = "R6 random";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) irq[$urandom_range(0, 31)] ^= 1'b1;
      we = ($urandom_range(0, 2) == 0);
      re = !we && ($urandom_range(0, 1) == 0);
      addr = 10'(32'h2E + $urandom_range(0, 12));
      wdata = $urandom();
      cyc();
    end
    we = 0; re = 0;
    cyc();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule